// File: doc/BRIEF.md
# Wake Pattern Detector

This block watches the receive byte stream of an Ethernet MAC that has been put into low-power mode. It searches each qualifying frame for a remote wake-up pattern. When a frame carries the pattern and also ends with a good frame check, the block pulls an active-low wake line. That line stays low until software clears it.

A frame is announced by a start strobe, which carries the destination class, and closed by an end strobe, which carries the CRC verdict. The pattern is a sync run of 0xFF bytes followed by a fixed number of back-to-back copies of the station's 48-bit address. It may begin at any byte of the frame. The search runs on the fly, one byte per valid cycle, and keeps no copy of the frame.

Top module: `wake_pattern_det`

## Requirements
- R1: After reset `wake_n` is high and no partial match is held.
- R2: While `scan_en` is low, no frame can pull `wake_n` low. Lowering `scan_en` releases a held wake on the next cycle.
- R3: A frame is scanned only if `rx_dst_class`, sampled with `rx_sof`, is 1 (own unicast), 2 (multicast) or 3 (broadcast). A frame with class 0 never wakes.
- R4: The pattern is 6 bytes of 0xFF followed by 16 uninterrupted copies of `station_addr`, sent most significant byte first (bits 47:40 first). It is found at any byte offset, including offset 0.
- R5: A frame that holds the pattern but ends with `rx_crc_ok` low at `rx_eof` does not wake.
- R6: A sync run longer than six 0xFF bytes still qualifies. An address whose leading bytes are 0xFF is still found after the sync run.
- R7: A mismatch during the address copies restarts the search. A 0xFF byte at the mismatch counts as the first sync byte, and any other byte leaves the sync count at zero.
- R8: Partial matches never carry across frames, and a pattern with only 15 address copies does not wake.
- R9: Once low, `wake_n` holds until a cycle with `wake_clr` high. A clear in the same cycle as a qualifying end of frame wins.
- R10: `wake_n` falls on the clock edge that samples the qualifying `rx_eof`, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Wake detection enable |
| station_addr | input | 48 | Station address, bits 47:40 sent first |
| rx_sof | input | 1 | Start-of-frame strobe (carries no byte) |
| rx_dst_class | input | 2 | Destination class, valid with `rx_sof` |
| rx_valid | input | 1 | Frame byte valid |
| rx_byte | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame strobe (carries no byte) |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_eof` |
| wake_clr | input | 1 | Clear pulse for the held wake |
| wake_n | output | 1 | Active-low wake, registered and held |

## Verification
On every cycle, the assertions check that a clear or a dropped enable releases the wake line. They also check that the line only falls at a good end of frame, that a held wake stays held, that frame boundaries wipe the search state, and that a mismatch restarts the sync count as R7 describes. Only the bench scenarios can show that the full pattern is recognised at arbitrary offsets, with long sync runs and with 0xFF-led addresses. The same applies to near-miss patterns of 15 copies, to patterns split across two frames, and to the gating by destination class and CRC.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  typedef enum logic [1:0] {
    DST_OTHER   = 2'd0,
    DST_UNICAST = 2'd1,
    DST_MULTI   = 2'd2,
    DST_BCAST   = 2'd3
  } dst_class_t;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/wpd_addr_lane.sv
module wpd_addr_lane #(
  parameter int ADDR_BYTES = 6,
  localparam int PW = $clog2(ADDR_BYTES + 1)
) (
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [PW-1:0]           sel,
  output logic [7:0]              lane_byte,
  output logic [PW-1:0]           lead_ff,
  output logic                    all_ff
);
  import wpd_pkg::*;

  logic [7:0] lanes [ADDR_BYTES];

  // lane 0 is the first byte on the wire (most significant)
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign lanes[g] = station_addr[8*(ADDR_BYTES-g)-1 -: 8];
  end

  always_comb begin
    lane_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (sel == PW'(i)) lane_byte = lanes[i];
    end
  end

  // number of 0xFF bytes that lead the address
  always_comb begin
    lead_ff = PW'(ADDR_BYTES);
    for (int i = ADDR_BYTES - 1; i >= 0; i--) begin
      if (lanes[i] != SYNC_BYTE) lead_ff = PW'(i);
    end
  end

  assign all_ff = (lead_ff == PW'(ADDR_BYTES));
endmodule

// File: rtl/wpd_seq_track.sv
module wpd_seq_track #(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPS       = 16,
  localparam int PW      = $clog2(ADDR_BYTES + 1),
  localparam int IW      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int RW      = (REPS > 1) ? $clog2(REPS) : 1,
  localparam int RUN_MAX = SYNC_LEN + ADDR_BYTES,
  localparam int NW      = $clog2(RUN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic [7:0]    lane_byte,
  input  logic [PW-1:0] lead_ff,
  input  logic          all_ff,
  output logic [PW-1:0] sel,
  output logic          found
);
  import wpd_pkg::*;

  logic          in_addr;
  logic [IW-1:0] idx;
  logic [RW-1:0] rep;
  logic [NW-1:0] run;

  logic          is_ff, hit, enter, last_byte, last_rep;
  logic [IW-1:0] cur_idx;
  logic [RW-1:0] cur_rep;
  logic [NW-1:0] thresh;

  always_comb begin
    sel       = in_addr ? PW'(idx) : lead_ff;
    is_ff     = (byte_in == SYNC_BYTE);
    hit       = (byte_in == lane_byte);
    thresh    = NW'(SYNC_LEN) + NW'(lead_ff);
    enter     = !in_addr && !is_ff && !all_ff && (run >= thresh) && hit;
    cur_idx   = in_addr ? idx : IW'(lead_ff);
    cur_rep   = in_addr ? rep : '0;
    last_byte = (cur_idx == IW'(ADDR_BYTES - 1));
    last_rep  = (cur_rep == RW'(REPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      in_addr <= 1'b0;
      idx     <= '0;
      rep     <= '0;
      run     <= '0;
      found   <= 1'b0;
    end else if (byte_vld && !found) begin
      if (in_addr && !hit) begin
        in_addr <= 1'b0;
        run     <= is_ff ? NW'(1) : '0;
      end else if (in_addr || enter) begin
        if (last_byte && last_rep) begin
          found   <= 1'b1;
          in_addr <= 1'b0;
          run     <= '0;
        end else begin
          in_addr <= 1'b1;
          idx     <= last_byte ? '0 : cur_idx + IW'(1);
          rep     <= last_byte ? cur_rep + RW'(1) : cur_rep;
        end
      end else if (is_ff) begin
        if (run != NW'(RUN_MAX)) run <= run + NW'(1);
      end else begin
        run <= '0;
      end
    end
  end

  // R8: a frame boundary leaves no partial state behind
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!found && !in_addr && run == '0));

  // R4: completion only ever follows an accepted byte
  a_r4_found_on_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(byte_vld));

  // R7: a broken copy drops to sync search, a 0xFF counting once
  a_r7_mismatch_restart: assert property (@(posedge clk) disable iff (rst)
    (in_addr && byte_vld && !hit && !restart) |=>
      (!in_addr && run == ($past(is_ff) ? NW'(1) : NW'(0))));
endmodule

// File: rtl/wpd_wake_hold.sv
module wpd_wake_hold (
  input  logic       clk,
  input  logic       rst,
  input  logic       scan_en,
  input  logic       sof,
  input  logic [1:0] dst_class,
  input  logic       eof,
  input  logic       crc_ok,
  input  logic       found,
  input  logic       wake_clr,
  output logic       scan_on,
  output logic       restart,
  output logic       wake_n
);
  import wpd_pkg::*;

  logic       frame_ok;
  dst_class_t cls;

  assign cls     = dst_class_t'(dst_class);
  assign scan_on = frame_ok;
  assign restart = sof || eof || !scan_en;

  always_ff @(posedge clk) begin
    if (rst || !scan_en || eof) frame_ok <= 1'b0;
    else if (sof)               frame_ok <= (cls != DST_OTHER);
  end

  always_ff @(posedge clk) begin
    if (rst || wake_clr || !scan_en)          wake_n <= 1'b1;
    else if (eof && frame_ok && crc_ok && found) wake_n <= 1'b0;
  end

  a_r9_clear_releases: assert property (@(posedge clk) disable iff (rst)
    wake_clr |=> wake_n);

  a_r2_disable_releases: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> wake_n);

  a_r10_fall_at_eof: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_n) |-> $past(eof && crc_ok));

  a_r9_holds: assert property (@(posedge clk) disable iff (rst)
    (!wake_n && !wake_clr && scan_en) |=> !wake_n);
endmodule

// File: rtl/wake_pattern_det.sv
module wake_pattern_det #(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPS       = 16,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int PW = $clog2(ADDR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_en,
  input  logic [AW-1:0] station_addr,
  input  logic          rx_sof,
  input  logic [1:0]    rx_dst_class,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_eof,
  input  logic          rx_crc_ok,
  input  logic          wake_clr,
  output logic          wake_n
);
  logic [PW-1:0] sel, lead_ff;
  logic [7:0]    lane_byte;
  logic          all_ff, found, scan_on, restart;

  wpd_addr_lane #(.ADDR_BYTES(ADDR_BYTES)) u_lane (
    .station_addr (station_addr),
    .sel          (sel),
    .lane_byte    (lane_byte),
    .lead_ff      (lead_ff),
    .all_ff       (all_ff)
  );

  wpd_seq_track #(.ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .REPS(REPS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .byte_vld  (rx_valid && scan_on),
    .byte_in   (rx_byte),
    .lane_byte (lane_byte),
    .lead_ff   (lead_ff),
    .all_ff    (all_ff),
    .sel       (sel),
    .found     (found)
  );

  wpd_wake_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .sof       (rx_sof),
    .dst_class (rx_dst_class),
    .eof       (rx_eof),
    .crc_ok    (rx_crc_ok),
    .found     (found),
    .wake_clr  (wake_clr),
    .scan_on   (scan_on),
    .restart   (restart),
    .wake_n    (wake_n)
  );
endmodule

// File: tb/wake_pattern_det_bench.sv
module wake_pattern_det_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_en = 1'b0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic        rx_sof = 1'b0;
  logic [1:0]  rx_dst_class = 2'd0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_eof = 1'b0;
  logic        rx_crc_ok = 1'b0;
  logic        wake_clr = 1'b0;
  logic        wake_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic pre_eof_wake;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  wake_pattern_det u_wake_pattern_det (
    .clk(clk), .rst(rst), .scan_en(scan_en), .station_addr(station_addr),
    .rx_sof(rx_sof), .rx_dst_class(rx_dst_class), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
    .wake_clr(wake_clr), .wake_n(wake_n)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wake_n=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic push_fill(input int n, input int seed);
    for (int i = 0; i < n; i++) q.push_back(8'((seed + 7 * i) % 200));
  endtask

  task automatic push_sync(input int n);
    for (int i = 0; i < n; i++) q.push_back(8'hFF);
  endtask

  task automatic push_reps(input int n);
    for (int r = 0; r < n; r++)
      for (int b = 5; b >= 0; b--) q.push_back(station_addr[8*b +: 8]);
  endtask

  task automatic send_frame(input logic [1:0] cls, input logic crc, input logic clr);
    @(negedge clk);
    rx_sof = 1'b1; rx_dst_class = cls;
    @(negedge clk);
    rx_sof = 1'b0;
    foreach (q[i]) begin
      rx_valid = 1'b1; rx_byte = q[i];
      @(negedge clk);
    end
    rx_valid = 1'b0;
    pre_eof_wake = wake_n;
    rx_eof = 1'b1; rx_crc_ok = crc; wake_clr = clr;
    @(negedge clk);
    rx_eof = 1'b0; rx_crc_ok = 1'b0; wake_clr = 1'b0;
    q.delete();
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk); wake_clr = 1'b1;
    @(negedge clk); wake_clr = 1'b0;
    chk(wake_n, 1'b1, tag);
  endtask

  task automatic t_reset;
    chk(wake_n, 1'b1, "R1 reset state");
  endtask

  task automatic t_basic;
    push_fill(14, 3); push_sync(6); push_reps(16); push_fill(5, 9);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(pre_eof_wake, 1'b1, "R10 not low before eof edge");
    chk(wake_n, 1'b0, "R4 R10 pattern mid-frame wakes");
    repeat (6) @(negedge clk);
    chk(wake_n, 1'b0, "R9 wake held");
    do_clear("R9 clear releases");
  endtask

  task automatic t_offset0;
    push_sync(6); push_reps(16);
    send_frame(2'd3, 1'b1, 1'b0);
    chk(wake_n, 1'b0, "R4 pattern at offset 0");
    do_clear("R9 clear after offset0");
  endtask

  task automatic t_bad_crc;
    push_sync(6); push_reps(16);
    send_frame(2'd1, 1'b0, 1'b0);
    chk(wake_n, 1'b1, "R5 bad CRC no wake");
  endtask

  task automatic t_class;
    push_sync(6); push_reps(16);
    send_frame(2'd0, 1'b1, 1'b0);
    chk(wake_n, 1'b1, "R3 class 0 ignored");
    push_fill(3, 1); push_sync(6); push_reps(16);
    send_frame(2'd2, 1'b1, 1'b0);
    chk(wake_n, 1'b0, "R3 multicast scanned");
    do_clear("R9 clear after multicast");
  endtask

  task automatic t_enable;
    @(negedge clk); scan_en = 1'b0;
    push_sync(6); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b1, "R2 disabled no wake");
    @(negedge clk); scan_en = 1'b1;
    push_sync(6); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b0, "R2 enabled wakes");
    @(negedge clk); scan_en = 1'b0;
    @(negedge clk);
    chk(wake_n, 1'b1, "R2 drop enable releases");
    scan_en = 1'b1;
  endtask

  task automatic t_short;
    push_sync(6); push_reps(15); push_fill(4, 5);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b1, "R8 fifteen copies no wake");
  endtask

  task automatic t_long_sync;
    push_fill(2, 8); push_sync(9); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b0, "R6 long sync wakes");
    do_clear("R9 clear after long sync");
    station_addr = 48'hFF_12_34_56_78_9A;
    push_sync(6); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b0, "R6 FF-led address wakes");
    do_clear("R9 clear after FF-led");
    station_addr = 48'h02_11_22_33_44_55;
  endtask

  task automatic t_mismatch;
    push_sync(6); push_reps(3); q.push_back(8'hFF); push_sync(5); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b0, "R7 FF at mismatch counts as sync");
    do_clear("R9 clear after mismatch");
    push_sync(6); push_reps(3); q.push_back(8'h00); push_sync(5); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b1, "R7 non-FF mismatch resets sync");
  endtask

  task automatic t_split;
    push_sync(6); push_reps(8);
    send_frame(2'd1, 1'b1, 1'b0);
    push_reps(8);
    send_frame(2'd1, 1'b1, 1'b0);
    chk(wake_n, 1'b1, "R8 split across frames no wake");
  endtask

  task automatic t_clear_wins;
    push_sync(6); push_reps(16);
    send_frame(2'd1, 1'b1, 1'b1);
    chk(wake_n, 1'b1, "R9 clear wins over eof");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    scan_en = 1'b1;
    t_basic();
    t_offset0();
    t_bad_crc();
    t_class();
    t_enable();
    t_short();
    t_long_sync();
    t_mismatch();
    t_split();
    t_clear_wins();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule